// File: doc/BRIEF.md
# EDAC Check-Bit Injection Unit

This unit sits between the check-bit encoders and the write ports of a cache's tag RAM and data RAM. On every RAM write it decides which check bits are stored. Normal writes store the encoder output. Diagnostic writes take one of four sources: the encoder output, a software-loaded mask register used as-is, the encoder output XORed with that mask, or the check bits already stored at the target location. The last source lets a test change the data while the old code stays in place.

A one-shot arm flag injects faults into ordinary traffic. While the flag is set, the first normal data write stores its encoder bits XORed with the data mask register. The first tag replacement stores its encoder bits XORed with the tag mask register, but only when that register is nonzero. Either event drops the flag. A read-select input chooses whether diagnostic reads of the RAMs return the stored values or the stored check bits. Encoding, decoding and correction are handled outside this unit.

Top module: `edac_inject_unit`

## Requirements
- R1: After reset the arm flag is 0 and both mask registers are zero, so a diagnostic XOR write stores the encoder bits unchanged.
- R2: A normal write (valid, diagnostic bit 0) with the flag clear stores the encoder check bits on the data port and on the tag port.
- R3: A diagnostic write selects its check bits with ck_src_i. 00 selects the encoder bits, 01 selects the mask register, 10 selects the encoder bits XOR the mask, and 11 selects the old check bits. The data port uses the data mask and the tag port uses the tag mask.
- R4: A normal data write with the flag set stores, for each word, the encoder bits XOR that word's 7-bit slice of the data mask. Word k uses bits [7k+6:7k].
- R5: A tag replacement (normal tag write) with the flag set stores the encoder bits XOR the tag mask when the tag mask is nonzero, and the encoder bits unchanged when it is zero.
- R6: The flag clears on the edge after the first normal data write or tag replacement, including a tag replacement with a zero mask. Diagnostic writes and idle cycles leave the flag unchanged.
- R7: When a normal data write and a tag replacement fall in the same cycle with the flag set, both are masked and the flag is cleared.
- R8: arm_set_i sets the flag on the next edge and takes priority over a clear in the same cycle. A write in that cycle still sees the flag's old value.
- R9: When rd_ck_sel_i is 1, diagnostic reads return each word's check bits and the tag's check bits, zero-extended into the low bits. When it is 0, they return the stored data and tag.
- R10: The RAM write enables follow the valid inputs, and the data and tag values pass through unchanged.
- R11: A mask register write is applied on the clock edge and affects writes from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ck_src_i | input | 2 | Check-bit source for diagnostic writes |
| rd_ck_sel_i | input | 1 | Diagnostic read returns check bits when 1 |
| arm_set_i | input | 1 | Set the one-shot inject flag |
| dmask_we_i | input | 1 | Load data mask register |
| dmask_i | input | 28 | Data mask value, 7 bits per word |
| tmask_we_i | input | 1 | Load tag mask register |
| tmask_i | input | 7 | Tag mask value |
| dwr_valid_i | input | 1 | Data RAM write request |
| dwr_diag_i | input | 1 | Data write is diagnostic |
| dwr_data_i | input | 128 | Data to write |
| dwr_gen_ck_i | input | 28 | Encoder check bits for the data |
| dwr_old_ck_i | input | 28 | Check bits currently stored at the data location |
| twr_valid_i | input | 1 | Tag RAM write request |
| twr_diag_i | input | 1 | Tag write is diagnostic (0 = replacement) |
| twr_tag_i | input | 20 | Tag to write |
| twr_gen_ck_i | input | 7 | Encoder check bits for the tag |
| twr_old_ck_i | input | 7 | Check bits currently stored at the tag location |
| drd_data_i | input | 128 | Data read from the data RAM |
| drd_ck_i | input | 28 | Check bits read from the data RAM |
| trd_tag_i | input | 20 | Tag read from the tag RAM |
| trd_ck_i | input | 7 | Check bits read from the tag RAM |
| dram_we_o | output | 1 | Data RAM write enable |
| dram_data_o | output | 128 | Data RAM write data |
| dram_ck_o | output | 28 | Data RAM write check bits |
| tram_we_o | output | 1 | Tag RAM write enable |
| tram_tag_o | output | 20 | Tag RAM write tag |
| tram_ck_o | output | 7 | Tag RAM write check bits |
| diag_drd_o | output | 128 | Diagnostic data read result |
| diag_trd_o | output | 20 | Diagnostic tag read result |
| armed_o | output | 1 | Inject flag state |

## Verification
Two events can both consume the flag in one cycle: a normal data write and a tag replacement. The bench provokes this with directed cycles where both valids are high and both diagnostic bits are low, with both a nonzero and a zero tag mask. Long random runs also overlap the two ports freely, and some of those cycles carry arm_set_i. A reference model predicts each cycle from the requirements. It expects both ports to be masked in the overlap cycle, the tag port to be left alone when its mask is zero, and the flag to be down after the edge unless it was re-armed in that cycle.

// File: rtl/edac_inj_pkg.sv
package edac_inj_pkg;
  typedef enum logic [1:0] {
    CK_GEN  = 2'b00,
    CK_REPL = 2'b01,
    CK_XOR  = 2'b10,
    CK_KEEP = 2'b11
  } ck_src_e;
endpackage

// File: rtl/edac_inj_ctrl.sv
module edac_inj_ctrl #(
  parameter int unsigned DMASK_W = 28,
  parameter int unsigned TMASK_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arm_set_i,
  input  logic               dmask_we_i,
  input  logic [DMASK_W-1:0] dmask_i,
  input  logic               tmask_we_i,
  input  logic [TMASK_W-1:0] tmask_i,
  input  logic               data_norm_i,
  input  logic               tag_norm_i,
  output logic               armed_o,
  output logic [DMASK_W-1:0] dmask_o,
  output logic [TMASK_W-1:0] tmask_o,
  output logic               data_hit_o,
  output logic               tag_hit_o
);
  logic armed_q;
  logic consume;

  assign consume = data_norm_i | tag_norm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      dmask_o <= '0;
      tmask_o <= '0;
    end else begin
      // set wins over consumption
      if (arm_set_i)    armed_q <= 1'b1;
      else if (consume) armed_q <= 1'b0;
      if (dmask_we_i) dmask_o <= dmask_i;
      if (tmask_we_i) tmask_o <= tmask_i;
    end
  end

  assign armed_o    = armed_q;
  assign data_hit_o = armed_q & data_norm_i;
  // zero tag mask: no modification, flag still consumed
  assign tag_hit_o  = armed_q & tag_norm_i & (|tmask_o);

  AST_ARM_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && consume && !arm_set_i |=> !armed_q); // R6
  AST_ARM_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_set_i |=> armed_q); // R8
  AST_ARM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !consume && !arm_set_i |=> $stable(armed_q)); // R6
  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmask_we_i |=> tmask_o == $past(tmask_i)); // R11
endmodule

// File: rtl/edac_ck_sel.sv
module edac_ck_sel
  import edac_inj_pkg::*;
#(
  parameter int unsigned CK_W = 7
) (
  input  ck_src_e         src_i,
  input  logic            diag_i,
  input  logic            hit_i,
  input  logic [CK_W-1:0] gen_i,
  input  logic [CK_W-1:0] old_i,
  input  logic [CK_W-1:0] mask_i,
  output logic [CK_W-1:0] ck_o
);
  always_comb begin
    if (diag_i) begin
      unique case (src_i)
        CK_GEN:  ck_o = gen_i;
        CK_REPL: ck_o = mask_i;
        CK_XOR:  ck_o = gen_i ^ mask_i;
        CK_KEEP: ck_o = old_i;
        default: ck_o = gen_i;
      endcase
    end else begin
      ck_o = hit_i ? (gen_i ^ mask_i) : gen_i;
    end
  end
endmodule

// File: rtl/edac_diag_rd_mux.sv
module edac_diag_rd_mux #(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned DCK_W     = 7,
  parameter int unsigned TAG_W     = 20,
  parameter int unsigned TCK_W     = 7,
  localparam int unsigned DATA_W   = NUM_WORDS * WORD_W,
  localparam int unsigned DMASK_W  = NUM_WORDS * DCK_W
) (
  input  logic               ck_sel_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [DMASK_W-1:0] dck_i,
  input  logic [TAG_W-1:0]   tag_i,
  input  logic [TCK_W-1:0]   tck_i,
  output logic [DATA_W-1:0]  data_o,
  output logic [TAG_W-1:0]   tag_o
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] ck_ext;
    assign ck_ext = {{(WORD_W-DCK_W){1'b0}}, dck_i[w*DCK_W +: DCK_W]};
    assign data_o[w*WORD_W +: WORD_W] = ck_sel_i ? ck_ext : data_i[w*WORD_W +: WORD_W];
  end

  assign tag_o = ck_sel_i ? {{(TAG_W-TCK_W){1'b0}}, tck_i} : tag_i;
endmodule

// File: rtl/edac_inject_unit.sv
module edac_inject_unit
  import edac_inj_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned DCK_W     = 7,
  parameter int unsigned TAG_W     = 20,
  parameter int unsigned TCK_W     = 7,
  localparam int unsigned DATA_W   = NUM_WORDS * WORD_W,
  localparam int unsigned DMASK_W  = NUM_WORDS * DCK_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         ck_src_i,
  input  logic               rd_ck_sel_i,
  input  logic               arm_set_i,
  input  logic               dmask_we_i,
  input  logic [DMASK_W-1:0] dmask_i,
  input  logic               tmask_we_i,
  input  logic [TCK_W-1:0]   tmask_i,
  input  logic               dwr_valid_i,
  input  logic               dwr_diag_i,
  input  logic [DATA_W-1:0]  dwr_data_i,
  input  logic [DMASK_W-1:0] dwr_gen_ck_i,
  input  logic [DMASK_W-1:0] dwr_old_ck_i,
  input  logic               twr_valid_i,
  input  logic               twr_diag_i,
  input  logic [TAG_W-1:0]   twr_tag_i,
  input  logic [TCK_W-1:0]   twr_gen_ck_i,
  input  logic [TCK_W-1:0]   twr_old_ck_i,
  input  logic [DATA_W-1:0]  drd_data_i,
  input  logic [DMASK_W-1:0] drd_ck_i,
  input  logic [TAG_W-1:0]   trd_tag_i,
  input  logic [TCK_W-1:0]   trd_ck_i,
  output logic               dram_we_o,
  output logic [DATA_W-1:0]  dram_data_o,
  output logic [DMASK_W-1:0] dram_ck_o,
  output logic               tram_we_o,
  output logic [TAG_W-1:0]   tram_tag_o,
  output logic [TCK_W-1:0]   tram_ck_o,
  output logic [DATA_W-1:0]  diag_drd_o,
  output logic [TAG_W-1:0]   diag_trd_o,
  output logic               armed_o
);
  ck_src_e              src;
  logic                 data_norm, tag_norm;
  logic                 data_hit, tag_hit;
  logic [DMASK_W-1:0]   dmask_q;
  logic [TCK_W-1:0]     tmask_q;

  assign src       = ck_src_e'(ck_src_i);
  assign data_norm = dwr_valid_i & ~dwr_diag_i;
  assign tag_norm  = twr_valid_i & ~twr_diag_i;

  edac_inj_ctrl #(
    .DMASK_W(DMASK_W),
    .TMASK_W(TCK_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_set_i  (arm_set_i),
    .dmask_we_i (dmask_we_i),
    .dmask_i    (dmask_i),
    .tmask_we_i (tmask_we_i),
    .tmask_i    (tmask_i),
    .data_norm_i(data_norm),
    .tag_norm_i (tag_norm),
    .armed_o    (armed_o),
    .dmask_o    (dmask_q),
    .tmask_o    (tmask_q),
    .data_hit_o (data_hit),
    .tag_hit_o  (tag_hit)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_dck
    edac_ck_sel #(.CK_W(DCK_W)) u_sel (
      .src_i (src),
      .diag_i(dwr_diag_i),
      .hit_i (data_hit),
      .gen_i (dwr_gen_ck_i[w*DCK_W +: DCK_W]),
      .old_i (dwr_old_ck_i[w*DCK_W +: DCK_W]),
      .mask_i(dmask_q[w*DCK_W +: DCK_W]),
      .ck_o  (dram_ck_o[w*DCK_W +: DCK_W])
    );
  end

  edac_ck_sel #(.CK_W(TCK_W)) u_tck_sel (
    .src_i (src),
    .diag_i(twr_diag_i),
    .hit_i (tag_hit),
    .gen_i (twr_gen_ck_i),
    .old_i (twr_old_ck_i),
    .mask_i(tmask_q),
    .ck_o  (tram_ck_o)
  );

  assign dram_we_o   = dwr_valid_i;
  assign dram_data_o = dwr_data_i;
  assign tram_we_o   = twr_valid_i;
  assign tram_tag_o  = twr_tag_i;

  edac_diag_rd_mux #(
    .NUM_WORDS(NUM_WORDS),
    .WORD_W   (WORD_W),
    .DCK_W    (DCK_W),
    .TAG_W    (TAG_W),
    .TCK_W    (TCK_W)
  ) u_rd_mux (
    .ck_sel_i(rd_ck_sel_i),
    .data_i  (drd_data_i),
    .dck_i   (drd_ck_i),
    .tag_i   (trd_tag_i),
    .tck_i   (trd_ck_i),
    .data_o  (diag_drd_o),
    .tag_o   (diag_trd_o)
  );

  AST_NORM_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_norm && !armed_o |-> dram_ck_o == dwr_gen_ck_i); // R2
  AST_TAG_ZERO_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_norm && tmask_q == '0 |-> tram_ck_o == twr_gen_ck_i); // R5
  AST_DUAL_CONSUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o && data_norm && tag_norm && !arm_set_i |=> !armed_o); // R7
  AST_DIAG_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dwr_valid_i && dwr_diag_i && src == CK_KEEP |-> dram_ck_o == dwr_old_ck_i); // R3
endmodule

// File: tb/tb_edac_inject_unit.sv
`timescale 1ns/1ps
module tb_edac_inject_unit;
  localparam int NW = 4, WW = 32, DW = 7, TW = 20, TKW = 7;
  localparam int DATW = NW*WW, DMW = NW*DW;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [1:0]      ck_src;
  logic            rd_ck_sel, arm_set, dmask_we, tmask_we;
  logic [DMW-1:0]  dmask_in, dgen, dold, drd_ck;
  logic [TKW-1:0]  tmask_in, tgen, told, trd_ck;
  logic            dv, dd, tv, td;
  logic [DATW-1:0] ddata, drd_data;
  logic [TW-1:0]   ttag, trd_tag;
  logic            dram_we, tram_we, armed;
  logic [DATW-1:0] dram_data, diag_drd;
  logic [DMW-1:0]  dram_ck;
  logic [TW-1:0]   tram_tag, diag_trd;
  logic [TKW-1:0]  tram_ck;

  edac_inject_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .ck_src_i(ck_src), .rd_ck_sel_i(rd_ck_sel),
    .arm_set_i(arm_set), .dmask_we_i(dmask_we), .dmask_i(dmask_in),
    .tmask_we_i(tmask_we), .tmask_i(tmask_in),
    .dwr_valid_i(dv), .dwr_diag_i(dd), .dwr_data_i(ddata), .dwr_gen_ck_i(dgen), .dwr_old_ck_i(dold),
    .twr_valid_i(tv), .twr_diag_i(td), .twr_tag_i(ttag), .twr_gen_ck_i(tgen), .twr_old_ck_i(told),
    .drd_data_i(drd_data), .drd_ck_i(drd_ck), .trd_tag_i(trd_tag), .trd_ck_i(trd_ck),
    .dram_we_o(dram_we), .dram_data_o(dram_data), .dram_ck_o(dram_ck),
    .tram_we_o(tram_we), .tram_tag_o(tram_tag), .tram_ck_o(tram_ck),
    .diag_drd_o(diag_drd), .diag_trd_o(diag_trd), .armed_o(armed)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  // reference state
  bit m_armed;
  logic [DMW-1:0] m_dmask;
  logic [TKW-1:0] m_tmask;

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [TKW-1:0] sel(logic [1:0] s, logic [TKW-1:0] g, logic [TKW-1:0] o, logic [TKW-1:0] m);
    case (s)
      2'd0: return g;
      2'd1: return m;
      2'd2: return g ^ m;
      default: return o;
    endcase
  endfunction

  // lbl overrides the default requirement label of the check-bit and flag checks
  task automatic step(string lbl = "");
    logic [DMW-1:0] e_dck;
    logic [TKW-1:0] e_tck;
    logic [DATW-1:0] e_rd;
    logic [TW-1:0] e_trd;
    string ld, lt, la;
    bit consume;
    #1;
    for (int w = 0; w < NW; w++) begin
      logic [DW-1:0] g, o, m;
      g = dgen[w*DW +: DW]; o = dold[w*DW +: DW]; m = m_dmask[w*DW +: DW];
      if (dd) e_dck[w*DW +: DW] = sel(ck_src, g, o, m);
      else    e_dck[w*DW +: DW] = m_armed ? g ^ m : g;
      e_rd[w*WW +: WW] = rd_ck_sel ? {{(WW-DW){1'b0}}, drd_ck[w*DW +: DW]} : drd_data[w*WW +: WW];
    end
    if (td) e_tck = sel(ck_src, tgen, told, m_tmask);
    else    e_tck = (m_armed && m_tmask != 0) ? tgen ^ m_tmask : tgen;
    e_trd = rd_ck_sel ? {{(TW-TKW){1'b0}}, trd_ck} : trd_tag;
    ld = lbl != "" ? lbl : (dd ? "R3" : (m_armed ? "R4" : "R2"));
    lt = lbl != "" ? lbl : (td ? "R3" : (m_armed ? "R5" : "R2"));
    la = lbl != "" ? lbl : "R6";
    if (dv) chk(ld, dram_ck, e_dck);
    if (tv) chk(lt, tram_ck, e_tck);
    chk("R10", {dram_we, tram_we}, {dv, tv});
    chk("R10", dram_data, ddata);
    chk("R10", tram_tag, ttag);
    chk("R9", diag_drd, e_rd);
    chk("R9", diag_trd, e_trd);
    chk(la, armed, m_armed);
    @(posedge clk);
    consume = (dv && !dd) || (tv && !td);
    if (arm_set) m_armed = 1;
    else if (consume) m_armed = 0;
    if (dmask_we) m_dmask = dmask_in;
    if (tmask_we) m_tmask = tmask_in;
    @(negedge clk);
  endtask

  task automatic idle();
    arm_set = 0; dmask_we = 0; tmask_we = 0; dv = 0; tv = 0; dd = 0; td = 0;
  endtask

  task automatic rnd_data();
    for (int w = 0; w < NW; w++) begin
      ddata[w*WW +: WW] = $urandom; drd_data[w*WW +: WW] = $urandom;
    end
    dgen = {$urandom, $urandom}; dold = {$urandom, $urandom}; drd_ck = {$urandom, $urandom};
    tgen = TKW'($urandom); told = TKW'($urandom); trd_ck = TKW'($urandom);
    ttag = TW'($urandom); trd_tag = TW'($urandom);
    dmask_in = DMW'({$urandom, $urandom});
    tmask_in = ($urandom % 3 == 0) ? '0 : TKW'($urandom);
  endtask

  initial begin
    #(200000*5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(); rnd_data(); ck_src = 0; rd_ck_sel = 0;
    m_armed = 0; m_dmask = '0; m_tmask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, zero masks under diagnostic XOR
    dv = 1; dd = 1; tv = 1; td = 1; ck_src = 2'd2;
    step("R1");
    idle(); dv = 1; tv = 1; step("R2");
    // R11: load masks, then diag replace shows them
    idle(); dmask_we = 1; dmask_in = 28'h5A5_A5A5; tmask_we = 1; tmask_in = 7'h2B;
    step("R11");
    idle(); dv = 1; dd = 1; tv = 1; td = 1; ck_src = 2'd1; step("R11");
    // R3: each source
    for (int s = 0; s < 4; s++) begin
      rnd_data(); idle(); dv = 1; dd = 1; tv = 1; td = 1; ck_src = 2'(s); step("R3");
    end
    // R7: simultaneous consume with nonzero tag mask
    idle(); arm_set = 1; step("R8");
    idle(); dv = 1; tv = 1; step("R7");
    idle(); step("R7");
    // R5: zero tag mask is skipped but still consumes
    idle(); tmask_we = 1; tmask_in = '0; arm_set = 1; step("R8");
    idle(); tv = 1; step("R5");
    idle(); step("R6");
    // R6: diagnostic writes do not consume
    idle(); arm_set = 1; step("R8");
    idle(); dv = 1; dd = 1; tv = 1; td = 1; ck_src = 2'd2; step("R6");
    idle(); dv = 1; step("R4");
    idle(); step("R6");
    // R8: arm_set with consume in same cycle
    idle(); dv = 1; arm_set = 1; step("R8");
    idle(); step("R8");
    // R7: simultaneous with zero tag mask
    idle(); dv = 1; tv = 1; step("R7");
    // R9: read select both ways
    rnd_data(); idle(); rd_ck_sel = 1; step("R9");
    rd_ck_sel = 0; step("R9");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      rnd_data(); idle();
      arm_set   = ($urandom % 6) == 0;
      dmask_we  = ($urandom % 8) == 0;
      tmask_we  = ($urandom % 8) == 0;
      dv = $urandom % 2; dd = ($urandom % 3) == 0;
      tv = $urandom % 2; td = ($urandom % 3) == 0;
      ck_src = 2'($urandom); rd_ck_sel = $urandom % 2;
      step();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule